// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks the coherence state of every line in one private write-back cache attached to a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The block accepts processor requests that name a line index: read, write, evict and clean (write back but keep the line). For each request it decides whether the line can serve it locally or whether a bus transaction is needed. It then issues a bus read, a read-for-ownership, an invalidate broadcast or a writeback, one at a time, and updates the line state when the bus reports completion.

The block also watches transactions that other caches place on the bus. A snooped read of a line held here raises a shared response. A clean Exclusive copy drops to Shared. A snooped read that finds a Modified line is held off with a retry signal until the line has been written back, and the line then becomes Shared. Ownership-taking snoops invalidate the local copy. A Shared line never promotes itself to Exclusive. The data array, the tag compare and the bus arbiter are outside the block, and a line index stands in for the tag.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are low. State codes are I=00, S=01, E=10, M=11.
- R2: A read (op 00) to a line in M, E or S responds one cycle after it is accepted, with hit=1 and the state unchanged, and raises no bus request.
- R3: A read to an Invalid line raises a bus read (cmd 00) one cycle after acceptance. One cycle after bus_done the block responds with hit=0 and state E if bus_shared was low at done, or S if it was high.
- R4: A write (op 01) to a line in E or M hits one cycle after acceptance, leaves the line in M and uses no bus transaction.
- R5: A write to a Shared line issues an invalidate (cmd 10), and a write to an Invalid line issues a read-for-ownership (cmd 01). In both cases the line becomes M when the transaction completes.
- R6: An evict (op 10) drops a line in I, S or E to I at once as a hit. An M line is first written back (cmd 11) and then becomes I.
- R7: A clean (op 11) of an M line writes it back (cmd 11) and leaves it in E. A clean of any other line hits and leaves its state unchanged.
- R8: A snooped read-for-ownership (cmd 01) or invalidate (cmd 10) leaves the line Invalid from any state. Neither raises shared or retry.
- R9: A snooped read (cmd 00) of a line in E moves it to S, and a line in S stays S. snoop_shared is high in the cycle after any snooped read that finds the line valid, and low otherwise.
- R10: A snooped read of an M line raises snoop_retry and a writeback request (cmd 11) for that index one cycle later. Both hold until bus_done. One cycle after bus_done both are low and the line is S.
- R11: A bus request keeps its command and index stable until bus_done and drops in the cycle after bus_done. Only one request is outstanding at a time.
- R12: A snoop with cmd 11 has no effect on the line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present; taken when idle and no snoop is presented |
| cpu_req_op | input | 2 | 00 read, 01 write, 10 evict, 11 clean |
| cpu_req_idx | input | IDX_W | Line index of the request |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_hit | output | 1 | Request was served without a bus transaction |
| cpu_resp_state | output | 2 | Line state after the request |
| bus_req_valid | output | 1 | Bus transaction outstanding |
| bus_req_cmd | output | 2 | 00 read, 01 read-for-ownership, 10 invalidate, 11 writeback |
| bus_req_idx | output | IDX_W | Line index of the bus transaction |
| bus_done | input | 1 | Bus transaction completed |
| bus_shared | input | 1 | Another cache holds the line, sampled with bus_done on a fill |
| snoop_valid | input | 1 | Another cache's transaction is presented |
| snoop_cmd | input | 2 | 00 read, 01 read-for-ownership, 10 invalidate, 11 no effect |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_retry | output | 1 | Snooped read must be retried after the pending writeback |

## Verification
Every result is registered, so a hit response, a new bus request, a shared response or a retry appears one cycle after the request or snoop is accepted. A completion response appears one cycle after bus_done. The bench drives inputs on falling edges and reads outputs on the next falling edge, which falls after exactly one rising edge. While a bus request is open, the bench waits two more cycles before it raises bus_done, and it checks that the request has stayed stable through that wait. The final state of each line is read back at the ports with a clean probe. A Modified line answers the probe with a writeback request. Any other line answers it with a hit that returns its state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {LS_I = 2'b00, LS_S = 2'b01, LS_E = 2'b10, LS_M = 2'b11} line_st_t;
  typedef enum logic [1:0] {OP_RD = 2'b00, OP_WR = 2'b01, OP_EV = 2'b10, OP_CL = 2'b11} cpu_op_t;
  typedef enum logic [1:0] {BC_RD = 2'b00, BC_RFO = 2'b01, BC_INV = 2'b10, BC_WB = 2'b11} bus_cmd_t;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_state,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_state
);
  line_st_t st_q [NUM_LINES];

  assign rd_state = st_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_I;
    end else if (we) begin
      st_q[wr_idx] <= wr_state;
    end
  end
endmodule

// File: rtl/mesi_cpu_decide.sv
module mesi_cpu_decide
  import mesi_pkg::*;
(
  input  cpu_op_t  op,
  input  line_st_t cur,
  output logic     hit,
  output bus_cmd_t cmd,
  output line_st_t next_st,
  output line_st_t after_st,
  output logic     fill
);
  always_comb begin
    hit      = 1'b1;
    cmd      = BC_RD;
    next_st  = cur;
    after_st = cur;
    fill     = 1'b0;
    case (op)
      OP_RD: if (cur == LS_I) begin
        hit  = 1'b0;
        cmd  = BC_RD;
        fill = 1'b1;
      end
      OP_WR: begin
        next_st  = LS_M;
        after_st = LS_M;
        if (cur == LS_S) begin
          hit = 1'b0;
          cmd = BC_INV;
        end else if (cur == LS_I) begin
          hit = 1'b0;
          cmd = BC_RFO;
        end
      end
      OP_EV: if (cur == LS_M) begin
        hit      = 1'b0;
        cmd      = BC_WB;
        after_st = LS_I;
      end else begin
        next_st = LS_I;
      end
      default: if (cur == LS_M) begin
        hit      = 1'b0;
        cmd      = BC_WB;
        after_st = LS_E;
      end
    endcase
  end

  // R4: a write that hits must leave the line Modified
  always_comb begin
    if (op == OP_WR && hit) a_wr_hit_m_r4: assert (next_st == LS_M);
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req_valid,
  input  logic [1:0]       cpu_req_op,
  input  logic [IDX_W-1:0] cpu_req_idx,
  output logic             cpu_resp_valid,
  output logic             cpu_resp_hit,
  output logic [1:0]       cpu_resp_state,
  output logic             bus_req_valid,
  output logic [1:0]       bus_req_cmd,
  output logic [IDX_W-1:0] bus_req_idx,
  input  logic             bus_done,
  input  logic             bus_shared,
  input  logic             snoop_valid,
  input  logic [1:0]       snoop_cmd,
  input  logic [IDX_W-1:0] snoop_idx,
  output logic             snoop_shared,
  output logic             snoop_retry
);
  typedef enum logic [1:0] {F_IDLE, F_OWN, F_SWB} fsm_t;

  fsm_t             fsm_q;
  logic [IDX_W-1:0] pend_idx_q;
  line_st_t         pend_after_q;
  logic             pend_fill_q;

  line_st_t         cur_st;
  logic             arr_we;
  logic [IDX_W-1:0] arr_widx;
  line_st_t         arr_wst;

  logic     dec_hit, dec_fill;
  bus_cmd_t dec_cmd;
  line_st_t dec_next, dec_after;

  logic idle, take_snp, take_cpu, snp_rd, snp_own;
  line_st_t done_st;

  assign idle     = (fsm_q == F_IDLE);
  assign take_snp = idle && snoop_valid;
  assign take_cpu = idle && !snoop_valid && cpu_req_valid;
  assign snp_rd   = (snoop_cmd == BC_RD);
  assign snp_own  = (snoop_cmd == BC_RFO) || (snoop_cmd == BC_INV);
  assign done_st  = (fsm_q == F_SWB) ? LS_S :
                    pend_fill_q ? (bus_shared ? LS_S : LS_E) : pend_after_q;

  mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (snoop_valid ? snoop_idx : cpu_req_idx),
    .rd_state (cur_st),
    .we       (arr_we),
    .wr_idx   (arr_widx),
    .wr_state (arr_wst)
  );

  mesi_cpu_decide u_dec (
    .op       (cpu_op_t'(cpu_req_op)),
    .cur      (cur_st),
    .hit      (dec_hit),
    .cmd      (dec_cmd),
    .next_st  (dec_next),
    .after_st (dec_after),
    .fill     (dec_fill)
  );

  always_comb begin
    arr_we   = 1'b0;
    arr_widx = pend_idx_q;
    arr_wst  = done_st;
    if (!idle) begin
      arr_we = bus_done;
    end else if (take_snp) begin
      arr_widx = snoop_idx;
      arr_wst  = cur_st;
      if (snp_own) begin
        arr_we  = (cur_st != LS_I);
        arr_wst = LS_I;
      end else if (snp_rd && cur_st == LS_E) begin
        arr_we  = 1'b1;
        arr_wst = LS_S;
      end
    end else if (take_cpu && dec_hit) begin
      arr_we   = 1'b1;
      arr_widx = cpu_req_idx;
      arr_wst  = dec_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q          <= F_IDLE;
      pend_idx_q     <= '0;
      pend_after_q   <= LS_I;
      pend_fill_q    <= 1'b0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_hit   <= 1'b0;
      cpu_resp_state <= 2'b00;
      bus_req_valid  <= 1'b0;
      bus_req_cmd    <= 2'b00;
      bus_req_idx    <= '0;
      snoop_shared   <= 1'b0;
      snoop_retry    <= 1'b0;
    end else begin
      cpu_resp_valid <= 1'b0;
      snoop_shared   <= 1'b0;
      case (fsm_q)
        F_IDLE: begin
          if (take_snp) begin
            snoop_shared <= snp_rd && (cur_st != LS_I);
            if (snp_rd && cur_st == LS_M) begin
              fsm_q         <= F_SWB;
              snoop_retry   <= 1'b1;
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= BC_WB;
              bus_req_idx   <= snoop_idx;
              pend_idx_q    <= snoop_idx;
            end
          end else if (take_cpu) begin
            if (dec_hit) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_hit   <= 1'b1;
              cpu_resp_state <= dec_next;
            end else begin
              fsm_q         <= F_OWN;
              bus_req_valid <= 1'b1;
              bus_req_cmd   <= dec_cmd;
              bus_req_idx   <= cpu_req_idx;
              pend_idx_q    <= cpu_req_idx;
              pend_after_q  <= dec_after;
              pend_fill_q   <= dec_fill;
            end
          end
        end
        default: begin
          if (bus_done) begin
            fsm_q         <= F_IDLE;
            bus_req_valid <= 1'b0;
            snoop_retry   <= 1'b0;
            if (fsm_q == F_OWN) begin
              cpu_resp_valid <= 1'b1;
              cpu_resp_hit   <= 1'b0;
              cpu_resp_state <= done_st;
            end
          end
        end
      endcase
    end
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && !bus_done |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_idx));
  p_req_release_r11: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid && bus_done |=> !bus_req_valid);
  p_retry_wb_r10: assert property (@(posedge clk) disable iff (rst)
    snoop_retry |-> bus_req_valid && bus_req_cmd == 2'b11);
  p_m_snoop_retry_r10: assert property (@(posedge clk) disable iff (rst)
    take_snp && snp_rd && cur_st == LS_M |=> snoop_retry);
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |=> !cpu_resp_valid);
  p_hit_no_bus_r2: assert property (@(posedge clk) disable iff (rst)
    take_cpu && dec_hit |=> !bus_req_valid && cpu_resp_valid);
endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int NL = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0;
  logic [1:0] cpu_req_op = 2'b00;
  logic [IW-1:0] cpu_req_idx = '0;
  logic cpu_resp_valid, cpu_resp_hit;
  logic [1:0] cpu_resp_state;
  logic bus_req_valid;
  logic [1:0] bus_req_cmd;
  logic [IW-1:0] bus_req_idx;
  logic bus_done = 1'b0;
  logic bus_shared = 1'b0;
  logic snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'b00;
  logic [IW-1:0] snoop_idx = '0;
  logic snoop_shared, snoop_retry;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_req_idx(cpu_req_idx),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_hit(cpu_resp_hit), .cpu_resp_state(cpu_resp_state),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_idx(bus_req_idx),
    .bus_done(bus_done), .bus_shared(bus_shared),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_idx(snoop_idx),
    .snoop_shared(snoop_shared), .snoop_retry(snoop_retry)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // issue a processor op; returns hit, final state, bus command (-1 if none)
  task automatic cpu_op(input int op, input int idx, input bit sh, input string req,
                        output int hit, output int st, output int cmd);
    hit = -1; st = -1; cmd = -1;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = op[1:0]; cpu_req_idx = idx[IW-1:0];
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (cpu_resp_valid) begin
      hit = int'(cpu_resp_hit); st = int'(cpu_resp_state);
      chk(req, "no bus on hit", int'(bus_req_valid), 0);
    end else if (bus_req_valid) begin
      cmd = int'(bus_req_cmd);
      chk("R11", "req idx", int'(bus_req_idx), idx);
      repeat (2) @(negedge clk);
      chk("R11", "req held", int'(bus_req_valid) * 8 + int'(bus_req_cmd), 8 + cmd);
      bus_done = 1'b1; bus_shared = sh;
      @(negedge clk);
      bus_done = 1'b0; bus_shared = 1'b0;
      chk("R11", "req dropped", int'(bus_req_valid), 0);
      chk(req, "resp after done", int'(cpu_resp_valid), 1);
      hit = int'(cpu_resp_hit); st = int'(cpu_resp_state);
    end else begin
      chk(req, "no reaction", 0, 1);
    end
    @(negedge clk);
    chk(req, "resp pulse", int'(cpu_resp_valid), 0);
  endtask

  task automatic snoop(input int c, input int idx, output int shr, output int rty);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = c[1:0]; snoop_idx = idx[IW-1:0];
    @(negedge clk);
    snoop_valid = 1'b0;
    shr = int'(snoop_shared); rty = int'(snoop_retry);
    if (rty != 0) begin
      chk("R10", "wb request", int'(bus_req_valid) * 16 + int'(bus_req_cmd) * 4 + int'(bus_req_idx),
          16 + 12 + idx);
      @(negedge clk);
      chk("R10", "retry held", int'(snoop_retry), 1);
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
      chk("R10", "retry released", int'(snoop_retry) * 2 + int'(bus_req_valid), 0);
    end
  endtask

  // state read-back through a clean op: M answers with a writeback
  task automatic probe(input int idx, output int st);
    int h, s, c;
    cpu_op(3, idx, 1'b0, "R7", h, s, c);
    st = (c == 3) ? 3 : s;
  endtask

  task automatic setup(input int x, input int idx);
    int h, s, c, a, b;
    snoop(2, idx, a, b);
    if (x == 1) cpu_op(0, idx, 1'b1, "R3", h, s, c);
    if (x >= 2) cpu_op(0, idx, 1'b0, "R3", h, s, c);
    if (x == 3) cpu_op(1, idx, 1'b0, "R4", h, s, c);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "outputs idle", int'(cpu_resp_valid) + int'(bus_req_valid) + int'(snoop_shared) + int'(snoop_retry), 0);
    for (int i = 0; i < NL; i++) begin
      int st;
      probe(i, st);
      chk("R1", "line invalid", st, 0);
    end

    // processor op sweep: every state x op x shared
    for (int idx = 0; idx < NL; idx++)
      for (int x = 0; x < 4; x++)
        for (int op = 0; op < 4; op++)
          for (int sh = 0; sh < 2; sh++) begin
            int h, s, c, pst, eh, ec, ef;
            string rq;
            eh = 1; ec = -1; ef = x;
            case (op)
              0: begin rq = (x == 0) ? "R3" : "R2";
                 if (x == 0) begin eh = 0; ec = 0; ef = sh ? 1 : 2; end end
              1: begin rq = (x >= 2) ? "R4" : "R5"; ef = 3;
                 if (x == 1) begin eh = 0; ec = 2; end
                 if (x == 0) begin eh = 0; ec = 1; end end
              2: begin rq = "R6"; ef = 0; if (x == 3) begin eh = 0; ec = 3; end end
              default: begin rq = "R7"; if (x == 3) begin eh = 0; ec = 3; ef = 2; end end
            endcase
            setup(x, idx);
            cpu_op(op, idx, sh[0], rq, h, s, c);
            chk(rq, "hit", h, eh);
            chk(rq, "bus cmd", c, ec);
            chk(rq, "resp state", s, ef);
            probe(idx, pst);
            chk(rq, "final state", pst, ef);
          end

    // snoop sweep: every state x snoop command
    for (int idx = 0; idx < NL; idx++)
      for (int x = 0; x < 4; x++)
        for (int c = 0; c < 4; c++) begin
          int shr, rty, pst, esh, ert, ef;
          string rq;
          esh = 0; ert = 0; ef = x;
          if (c == 0) begin
            rq = (x == 3) ? "R10" : "R9";
            esh = (x != 0) ? 1 : 0; ert = (x == 3) ? 1 : 0;
            ef = (x == 0) ? 0 : 1;
          end else if (c == 3) begin
            rq = "R12";
          end else begin
            rq = "R8"; ef = 0;
          end
          setup(x, idx);
          snoop(c, idx, shr, rty);
          chk(rq, "shared", shr, esh);
          chk(rq, "retry", rty, ert);
          probe(idx, pst);
          chk(rq, "final state", pst, ef);
        end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule